// File: doc/BRIEF.md
# Debug Scan-Chain Selecting Test Access Port

This block is a boundary test access port whose data side is switched between several internal debug scan chains. A host drives the serial test clock, mode select and data input. It loads a 5-bit instruction, and when that instruction is the chain-select code it shifts a 5-bit chain number into a dedicated selection register. During the capture step that register presents a fixed marker value of 0x10. The host reads the marker back while it shifts the new number in, which lets it confirm that the serial link works. The new chain number takes effect only when the state machine passes Update-DR.

With one of the two scan-test instructions loaded, the serial path runs through the chain that is currently selected. The chains sit outside this block. Each one receives the serial data input, a one-hot enable and the capture, shift and update strobes, and returns one serial output bit. Chain 0 is the safe parked selection: no enable is raised for it, so nothing on the core side can act on it, not even on entry to Run-Test/Idle. Chain numbers with no chain behind them, and instruction codes the block does not decode, fall back to a one-bit bypass path. The serial output changes on the falling clock edge, and all inputs are sampled on the rising edge.

Top module: `jtag_chain_sel`

## Requirements
- R1: The controller follows the standard 16-state TAP graph. Test-Logic-Reset is reached when trstN is low, or after five rising edges with tms high from any state. In that state the instruction becomes 0x1F (bypass) and the active chain becomes 0.
- R2: The instruction register is 5 bits wide. It captures 5'b00001 and shifts least significant bit first. The shifted value becomes curInstr at Update-IR. Decoded codes are: chain-select 0x02, internal scan-test 0x0C, external scan-test 0x00, bypass 0x1F.
- R3: Under code 0x02, the data path is a 5-bit selection register. It loads 0x10 at Capture-DR and shifts least significant bit first.
- R4: activeChain changes only when the state machine passes Update-DR with code 0x02, or on a return to Test-Logic-Reset. Shifting and Exit1-DR leave it unchanged.
- R5: Under code 0x0C or 0x00, with activeChain between 1 and NCHAIN-1, chainEn[activeChain] is the only enable bit set. The data path is then chainTdo[activeChain].
- R6: Chain 0 and chain numbers of NCHAIN or more raise no chainEn bit. They shift through a 1-bit bypass register that captures 0.
- R7: Every other instruction code, bypass included, uses the 1-bit bypass register that captures 0. curInstr still reports the loaded code.
- R8: tdo changes only on the falling edge of tck. It is 0 outside Shift-IR and Shift-DR.
- R9: captureStb, shiftStb and updateStb are high exactly in Capture-DR, Shift-DR and Update-DR. idleEntryStb is high for only the first cycle of each stay in Run-Test/Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| curInstr | output | 5 | Instruction currently in force |
| activeChain | output | 5 | Chain number currently selected |
| chainEn | output | NCHAIN | One-hot enable of the chain being scanned |
| chainTdo | input | NCHAIN | Serial output bit of each debug chain |
| captureStb | output | 1 | High in Capture-DR |
| shiftStb | output | 1 | High in Shift-DR |
| updateStb | output | 1 | High in Update-DR |
| idleEntryStb | output | 1 | High on the first cycle of Run-Test/Idle |

## Verification
The selection step is tried with implemented odd chains, chain 0 and an unimplemented number, each followed by a scan under one of the two scan-test instructions. In that scan, an all-ones output stream shows routing to a real chain, and a one-bit-delayed copy of the input pattern shows the bypass fallback. For each selection, the marker read back during the shift and the chain number seen at Exit1-DR show that the capture and the Update-DR gating are correct. Directed sequences then cover an undecoded instruction, a mode-select reset from a selected chain, the one-cycle idle-entry pulse, and the falling-edge timing of the first instruction bit.

// File: rtl/jtag_sel_pkg.sv
package jtag_sel_pkg;
  localparam int IR_W = 5;

  localparam logic [IR_W-1:0] OP_EXT_SCAN = 5'h00;
  localparam logic [IR_W-1:0] OP_CHAINSEL = 5'h02;
  localparam logic [IR_W-1:0] OP_INT_SCAN = 5'h0C;
  localparam logic [IR_W-1:0] OP_BYPASS   = 5'h1F;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 5'b00001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE, ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  typedef struct packed {
    logic inReset;
    logic idleEntry;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobes_t;
endpackage

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_sel_pkg::*;
(
  input  logic        tck,
  input  logic        trstN,
  input  logic        tms,
  output tapStrobes_t strobes
);
  tapState_e state, nextState;
  logic wasIdle;

  always_comb begin
    unique case (state)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nextState = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nextState = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SHF_IR;
      default:   nextState = tms ? ST_SEL_DR : ST_IDLE;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      state   <= ST_RESET;
      wasIdle <= 1'b0;
    end else begin
      state   <= nextState;
      wasIdle <= (state == ST_IDLE);
    end
  end

  always_comb begin
    strobes.inReset   = (state == ST_RESET);
    strobes.idleEntry = (state == ST_IDLE) && !wasIdle;
    strobes.captureIr = (state == ST_CAP_IR);
    strobes.shiftIr   = (state == ST_SHF_IR);
    strobes.updateIr  = (state == ST_UPD_IR);
    strobes.captureDr = (state == ST_CAP_DR);
    strobes.shiftDr   = (state == ST_SHF_DR);
    strobes.updateDr  = (state == ST_UPD_DR);
  end
endmodule

// File: rtl/jtag_sel_datapath.sv
module jtag_sel_datapath
  import jtag_sel_pkg::*;
#(
  parameter int SEL_W  = 5,
  parameter int NCHAIN = 8,
  parameter logic [SEL_W-1:0] SEL_MARK = 5'h10
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tdi,
  input  tapStrobes_t       strobes,
  input  logic [NCHAIN-1:0] chainTdo,
  output logic              tdo,
  output logic [IR_W-1:0]   curInstr,
  output logic [SEL_W-1:0]  activeChain,
  output logic [NCHAIN-1:0] chainEn
);
  localparam int CIDX_W = (NCHAIN > 1) ? $clog2(NCHAIN) : 1;

  logic [IR_W-1:0]  irShift;
  logic [SEL_W-1:0] selShift;
  logic             bypassBit;
  logic             isSel, isScan, routed, tdoNext;

  assign isSel  = (curInstr == OP_CHAINSEL);
  assign isScan = (curInstr == OP_INT_SCAN) || (curInstr == OP_EXT_SCAN);
  assign routed = isScan && (activeChain != '0) && (activeChain < SEL_W'(NCHAIN));

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift     <= '0;
      curInstr    <= OP_BYPASS;
      selShift    <= '0;
      activeChain <= '0;
      bypassBit   <= 1'b0;
    end else begin
      if (strobes.captureIr)    irShift <= IR_CAPTURE;
      else if (strobes.shiftIr) irShift <= {tdi, irShift[IR_W-1:1]};

      if (strobes.inReset)       curInstr <= OP_BYPASS;
      else if (strobes.updateIr) curInstr <= irShift;

      if (strobes.captureDr && isSel)    selShift <= SEL_MARK;
      else if (strobes.shiftDr && isSel) selShift <= {tdi, selShift[SEL_W-1:1]};

      if (strobes.inReset)                activeChain <= '0;
      else if (strobes.updateDr && isSel) activeChain <= selShift;

      if (strobes.captureDr)    bypassBit <= 1'b0;
      else if (strobes.shiftDr) bypassBit <= tdi;
    end
  end

  for (genvar k = 0; k < NCHAIN; k++) begin : g_en
    if (k == 0) begin : g_park
      assign chainEn[k] = 1'b0;
    end else begin : g_live
      assign chainEn[k] = isScan && (activeChain == SEL_W'(k));
    end
  end

  always_comb begin
    tdoNext = 1'b0;
    if (strobes.shiftIr)                tdoNext = irShift[0];
    else if (strobes.shiftDr && isSel)  tdoNext = selShift[0];
    else if (strobes.shiftDr && routed) tdoNext = chainTdo[activeChain[CIDX_W-1:0]];
    else if (strobes.shiftDr)           tdoNext = bypassBit;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) tdo <= 1'b0;
    else        tdo <= tdoNext;
  end
endmodule

// File: rtl/jtag_chain_sel.sv
module jtag_chain_sel
  import jtag_sel_pkg::*;
#(
  parameter int SEL_W  = 5,
  parameter int NCHAIN = 8
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic [4:0]        curInstr,
  output logic [SEL_W-1:0]  activeChain,
  output logic [NCHAIN-1:0] chainEn,
  input  logic [NCHAIN-1:0] chainTdo,
  output logic              captureStb,
  output logic              shiftStb,
  output logic              updateStb,
  output logic              idleEntryStb
);
  tapStrobes_t strobes;

  jtag_tap_ctrl uCtrl (.tck(tck), .trstN(trstN), .tms(tms), .strobes(strobes));

  jtag_sel_datapath #(.SEL_W(SEL_W), .NCHAIN(NCHAIN)) uPath (
    .tck(tck), .trstN(trstN), .tdi(tdi), .strobes(strobes), .chainTdo(chainTdo),
    .tdo(tdo), .curInstr(curInstr), .activeChain(activeChain), .chainEn(chainEn)
  );

  assign captureStb   = strobes.captureDr;
  assign shiftStb     = strobes.shiftDr;
  assign updateStb    = strobes.updateDr;
  assign idleEntryStb = strobes.idleEntry;
endmodule

// File: rtl/jtag_chain_sel_chk.sv
module jtag_chain_sel_chk #(
  parameter int SEL_W  = 5,
  parameter int NCHAIN = 8
) (
  input logic              tck,
  input logic              trstN,
  input logic              tdo,
  input logic [SEL_W-1:0]  activeChain,
  input logic [NCHAIN-1:0] chainEn,
  input logic              captureStb,
  input logic              shiftStb,
  input logic              updateStb,
  input logic              idleEntryStb
);
  AST_SEL_AT_UPDATE: assert property (@(posedge tck) disable iff (!trstN)
    (activeChain != $past(activeChain)) |-> ($past(updateStb) || activeChain == '0)); // R4
  AST_EN_ONEHOT: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0(chainEn)); // R5
  AST_PARKED_SAFE: assert property (@(posedge tck) disable iff (!trstN)
    (activeChain == '0) |-> (chainEn == '0)); // R6
  AST_STROBE_EXCL: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({captureStb, shiftStb, updateStb, idleEntryStb})); // R9
  AST_IDLE_PULSE: assert property (@(posedge tck) disable iff (!trstN)
    idleEntryStb |=> !idleEntryStb); // R9
  AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!trstN)
    (captureStb || updateStb || idleEntryStb) |-> !tdo); // R8
endmodule

bind jtag_chain_sel jtag_chain_sel_chk #(.SEL_W(SEL_W), .NCHAIN(NCHAIN)) uChk (.*);

// File: tb/sim_jtag_chain_sel.sv
`timescale 1ns/1ps
module sim_jtag_chain_sel;
  localparam int NCHAIN = 8;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, captureStb, shiftStb, updateStb, idleEntryStb;
  logic [4:0] curInstr, activeChain;
  logic [NCHAIN-1:0] chainEn;
  logic [NCHAIN-1:0] chainTdo = 8'b1010_1010;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  jtag_chain_sel #(.SEL_W(5), .NCHAIN(NCHAIN)) u0 (.*);

  always #4 tck = ~tck;

  // {instruction, chain number}
  localparam logic [9:0] VEC [5] = '{
    {5'h0C, 5'd3}, {5'h00, 5'd5}, {5'h0C, 5'd0}, {5'h00, 5'd9}, {5'h0C, 5'd7}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic t, input logic d, output logic o);
    tms = t; tdi = d;
    #3; o = tdo;
    @(posedge tck); #2;
  endtask

  task automatic loadIr(input logic [4:0] code, output logic [4:0] cap);
    logic o;
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 5; i++) begin
      tick(i == 4, code[i], o); cap[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic scanDr(input int n, input logic [7:0] din, output logic [7:0] dout,
                        output logic [4:0] chainAtExit, output logic sawCap, output logic sawUpd);
    logic o;
    dout = '0;
    tick(1, 0, o); tick(0, 0, o);
    sawCap = captureStb;
    tick(0, 0, o);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o); dout[i] = o;
    end
    chainAtExit = activeChain;
    tick(1, 0, o);
    sawUpd = updateStb;
    tick(0, 0, o);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic o, capS, updS;
    logic [4:0] cap, exitCh, prevChain;
    logic [7:0] dout;
    #10;
    check(curInstr == 5'h1F, "R1 reset instr", curInstr, 5'h1F);
    check(activeChain == 0, "R1 reset chain", activeChain, 0);
    check(tdo == 0 && chainEn == 0, "R8 reset tdo/en", {tdo, chainEn}, 0);
    trstN = 1'b1;
    @(posedge tck); #2;
    tick(0, 0, o);
    check(idleEntryStb == 1, "R9 idle entry pulse", idleEntryStb, 1);
    tick(0, 0, o);
    check(idleEntryStb == 0, "R9 idle pulse ends", idleEntryStb, 0);

    prevChain = 0;
    for (int v = 0; v < 5; v++) begin
      logic [4:0] op, ch;
      logic [7:0] expOut;
      logic [NCHAIN-1:0] expEn;
      bit live;
      op = VEC[v][9:5]; ch = VEC[v][4:0];
      loadIr(5'h02, cap);
      check(cap == 5'b00001, "R2 ir capture", cap, 1);
      check(curInstr == 5'h02, "R2 chainsel loaded", curInstr, 2);
      scanDr(5, {3'b0, ch}, dout, exitCh, capS, updS);
      check(dout[4:0] == 5'h10, "R3 select marker", dout[4:0], 5'h10);
      check(capS && updS, "R9 capture/update strobes", {capS, updS}, 3);
      check(exitCh == prevChain, "R4 no change before update", exitCh, prevChain);
      check(activeChain == ch, "R4 chain after update", activeChain, ch);
      prevChain = ch;
      loadIr(op, cap);
      check(curInstr == op, "R2 scan instr loaded", curInstr, op);
      live = (ch >= 1) && (ch < NCHAIN);
      expEn = live ? (NCHAIN'(1) << ch) : '0;
      check(chainEn == expEn, live ? "R5 chain enable" : "R6 no enable", chainEn, expEn);
      scanDr(8, 8'hA5, dout, exitCh, capS, updS);
      expOut = live ? {8{ch[0]}} : {8'hA5 << 1};
      check(dout == expOut, live ? "R5 routed data" : "R6 bypass data", dout, expOut);
      check(activeChain == ch, "R4 scan keeps chain", activeChain, ch);
    end

    loadIr(5'h05, cap);
    check(curInstr == 5'h05, "R7 odd code reported", curInstr, 5);
    scanDr(8, 8'h3C, dout, exitCh, capS, updS);
    check(dout == 8'h78, "R7 bypass for odd code", dout, 8'h78);
    check(chainEn == 0, "R7 no enable", chainEn, 0);

    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    check(tdo == 0, "R8 tdo before falling edge", tdo, 0);
    #3;
    check(tdo == 1, "R8 tdo after falling edge", tdo, 1);
    #5;
    tick(1, 1, o);
    for (int i = 0; i < 6; i++) tick(1, 0, o);
    check(curInstr == 5'h1F, "R1 tms reset instr", curInstr, 5'h1F);
    check(activeChain == 0, "R1 tms reset chain", activeChain, 0);
    tick(0, 0, o);
    check(idleEntryStb == 1, "R9 idle after reset", idleEntryStb, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule